// File: doc/BRIEF.md
# Stream Tag Extractor with Buffer Pointer

This block sits on an incoming stream of 32-bit words that is being stored in a circular buffer memory. It owns the buffer write pointer and presents one write per accepted word at the current pointer. Words are written only while the buffer has room. The host advances a read pointer, and the buffer may be filled up to one slot below it. When that limit is reached, the block withdraws its input ready.

While words flow into the buffer, the block copies selected words into a small extracts FIFO. The host later reads this FIFO to find packet boundaries and header fields without scanning the buffer. A copied word is one that carries a start, end or error tag, or one whose position inside the current packet equals one of eight programmable offsets. Each FIFO entry keeps the data word, the buffer position it was written to, and the reason it was copied. The host can read the head entry without removing it (peek), or remove it (pop).

Packet tracking uses a two-state machine. In `ST_OUT` no packet is open. In `ST_IN` a packet is open. The transition PKT_OPEN (`ST_OUT` to `ST_IN`) happens when an accepted word carries the start tag and no end tag. The transition PKT_CLOSE (`ST_IN` to `ST_OUT`) happens when an accepted word carries the end tag. A start tag seen in `ST_IN` restarts the position count and stays in `ST_IN`.

Top module: `stream_tag_extractor`

## Requirements
- R1: After reset the write pointer and read pointer are 0, the extracts FIFO is empty, `ext_head` reads 64'h8000_0000_0000_0000, all eight offsets hold 6, and `in_ready` is high.
- R2: Each accepted word (`in_valid` and `in_ready` both high) is presented as a buffer write: `mem_we` high, `mem_addr` equal to the write pointer, and `mem_wdata` equal to `in_data`. The write pointer then advances by one, modulo 2^AW.
- R3: The buffer counts as full when write pointer + 1 equals the read pointer (modulo 2^AW). While full, `st_mem_full` is high, `in_ready` is low, and no write occurs. Writing the read pointer through `rdptr_we` releases the condition.
- R4: A word with `in_sop`, `in_eop` or `in_err` set is always copied to the FIFO. Bit 58 records the start tag, bit 59 the error tag, and bit 60 the end tag.
- R5: Inside a packet, positions are counted from the start word (position 0). A word whose position equals any of the eight offsets is copied with bit 61 set. With the reset offsets, the seventh word (position 6) is copied.
- R6: If several offsets hold the same value, the matching word produces exactly one FIFO entry.
- R7: An offset write updates offset i from `ofs_wdata[8i+7:8i]` only where `ofs_be[i]` is set. Other offsets keep their values.
- R8: The entry layout is: bits 31:0 hold the data word, bits 32 upward (AW bits) hold the buffer address the word was written to, bit 62 is 0, and bit 63 is set only when the FIFO is empty. In that case every other bit reads 0.
- R9: A read (`ext_rd`) pops the head only when `ext_rd_lo` (the lowest byte lane) is set. A read without it is a peek and leaves the FIFO unchanged.
- R10: While the extracts FIFO is full, `in_ready` is low, so no word is lost.
- R11: `st_wr_en` is high in a cycle where a word is accepted. `st_tag_match` is high in a cycle where an accepted word is copied. `st_wptr` shows the write pointer, and `st_fill` shows the FIFO occupancy as a 10-bit count.
- R12: Outside a packet (after the end word and before the next start), untagged words are not copied, whatever the offsets hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Input data word |
| in_sop | input | 1 | Start-of-packet tag |
| in_eop | input | 1 | End-of-packet tag |
| in_err | input | 1 | Error tag |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | AW | Buffer write address |
| mem_wdata | output | 32 | Buffer write data |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_be | input | 8 | Per-offset byte enables |
| ofs_wdata | input | 64 | Offset write data, byte i for offset i |
| rdptr_we | input | 1 | Read pointer write strobe |
| rdptr_wdata | input | AW | New read pointer |
| ext_rd | input | 1 | Extracts FIFO read strobe |
| ext_rd_lo | input | 1 | Read includes the lowest byte lane (pop) |
| ext_head | output | 64 | Head entry of the extracts FIFO |
| st_mem_full | output | 1 | Buffer full status |
| st_wr_en | output | 1 | Word accepted this cycle |
| st_tag_match | output | 1 | Accepted word is being copied |
| st_wptr | output | AW | Current write pointer |
| st_fill | output | 10 | Extracts FIFO occupancy |

## Verification
The assertions check on every cycle:
- no buffer write happens while the buffer is full;
- the write pointer moves by exactly one per accepted word and holds otherwise;
- the FIFO is never pushed while full, and its occupancy never exceeds its depth;
- the packet state follows the PKT_OPEN and PKT_CLOSE transitions.

Only the bench scenarios can show the rest: which words are selected, the single entry produced by duplicate offsets, the entry fields with their stored pointer, the peek versus pop difference, the pointer wrap, and release of the full condition by a read pointer update.

// File: rtl/ste_pkg.sv
package ste_pkg;
    typedef enum logic [0:0] {
        ST_OUT = 1'b0,
        ST_IN  = 1'b1
    } pkt_state_t;

    localparam int OFS_NUM   = 8;
    localparam int OFS_W     = 8;
    localparam int POS_W     = OFS_W + 1;
    localparam int DATA_W    = 32;
    localparam int ENTRY_W   = 64;
    localparam int FILL_W    = 10;
    localparam int BIT_SOP   = 58;
    localparam int BIT_ERR   = 59;
    localparam int BIT_EOP   = 60;
    localparam int BIT_HDR   = 61;
    localparam int BIT_EMPTY = 63;
    localparam logic [OFS_W-1:0] OFS_RESET = 8'd6;
endpackage

// File: rtl/ste_offset_regs.sv
module ste_offset_regs
    import ste_pkg::*;
#(
    parameter int NUM = OFS_NUM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [NUM-1:0]       be,
    input  logic [NUM*OFS_W-1:0] wdata,
    input  logic [POS_W-1:0]     pos,
    input  logic                 pos_valid,
    output logic                 hit
);
    logic [NUM-1:0] match;

    for (genvar i = 0; i < NUM; i++) begin : g_ofs
        logic [OFS_W-1:0] ofs_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q <= OFS_RESET;
            end else if (wr && be[i]) begin
                ofs_q <= wdata[i*OFS_W +: OFS_W];
            end
        end

        assign match[i] = ({1'b0, ofs_q} == pos);
    end

    // several equal offsets collapse into one hit
    assign hit = pos_valid && (|match);
endmodule

// File: rtl/ste_ptr_ctrl.sv
module ste_ptr_ctrl #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic          rp_we,
    input  logic [AW-1:0] rp_wdata,
    output logic [AW-1:0] wptr,
    output logic          mem_full
);
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_acc) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (rp_we) begin
                rptr_q <= rp_wdata;
            end
        end
    end

    assign wptr     = wptr_q;
    assign mem_full = ((wptr_q + 1'b1) == rptr_q);

    // R3
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> !mem_full);

    // R2
    wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (wptr_q == $past(wptr_q) + 1'b1));

    // R2
    wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(wptr_q));
endmodule

// File: rtl/ste_extract_fifo.sv
module ste_extract_fifo #(
    parameter int PW    = 40,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PW-1:0]   pay_in,
    input  logic            pop_req,
    output logic [PW-1:0]   head,
    output logic            empty,
    output logic            full,
    output logic [9:0]      fill
);
    localparam int LW = $clog2(DEPTH);
    localparam int FW = LW + 1;

    logic [PW-1:0] store [DEPTH];
    logic [FW-1:0] wr_q;
    logic [FW-1:0] rd_q;
    logic [FW-1:0] cnt;
    logic          do_pop;

    assign cnt    = wr_q - rd_q;
    assign empty  = (cnt == '0);
    assign full   = (cnt == FW'(DEPTH));
    assign do_pop = pop_req && !empty;
    assign head   = store[rd_q[LW-1:0]];
    assign fill   = 10'(cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) begin
                wr_q <= wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= rd_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_q[LW-1:0]] <= pay_in;
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FW'(DEPTH));

    // R9
    push_only_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_req) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/stream_tag_extractor.sv
module stream_tag_extractor
    import ste_pkg::*;
#(
    parameter int AW         = 10,
    parameter int FIFO_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          in_err,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          ofs_we,
    input  logic [7:0]    ofs_be,
    input  logic [63:0]   ofs_wdata,
    input  logic          rdptr_we,
    input  logic [AW-1:0] rdptr_wdata,
    input  logic          ext_rd,
    input  logic          ext_rd_lo,
    output logic [63:0]   ext_head,
    output logic          st_mem_full,
    output logic          st_wr_en,
    output logic          st_tag_match,
    output logic [AW-1:0] st_wptr,
    output logic [9:0]    st_fill
);
    localparam int PW = DATA_W + AW + 4;
    localparam logic [POS_W-1:0] POS_SAT = {1'b1, {OFS_W{1'b0}}};

    pkt_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;
    logic             pos_valid;
    logic             hit;
    logic             acc;
    logic             extract;
    logic             mem_full;
    logic             fifo_full;
    logic             fifo_empty;
    logic [AW-1:0]    wptr;
    logic [PW-1:0]    pay_in;
    logic [PW-1:0]    pay_head;

    assign in_ready  = !mem_full && !fifo_full;
    assign acc       = in_valid && in_ready;
    assign cur_pos   = in_sop ? '0 : pos_q;
    assign pos_valid = in_sop || (state_q == ST_IN);

    ste_offset_regs #(.NUM(OFS_NUM)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ofs_we),
        .be        (ofs_be),
        .wdata     (ofs_wdata),
        .pos       (cur_pos),
        .pos_valid (pos_valid),
        .hit       (hit)
    );

    ste_ptr_ctrl #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (acc),
        .rp_we    (rdptr_we),
        .rp_wdata (rdptr_wdata),
        .wptr     (wptr),
        .mem_full (mem_full)
    );

    ste_extract_fifo #(.PW(PW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (extract),
        .pay_in  (pay_in),
        .pop_req (ext_rd && ext_rd_lo),
        .head    (pay_head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .fill    (st_fill)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OUT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: PKT_OPEN and PKT_CLOSE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OUT: if (acc && in_sop && !in_eop) state_d = ST_IN;
            ST_IN:  if (acc && in_eop)            state_d = ST_OUT;
            default: state_d = ST_OUT;
        endcase
    end

    // position of the next word inside the open packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (acc && in_sop) begin
            pos_q <= POS_W'(1);
        end else if (acc && (state_q == ST_IN) && (pos_q != POS_SAT)) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_we       = acc;
        mem_addr     = wptr;
        mem_wdata    = in_data;
        extract      = acc && (in_sop || in_eop || in_err || hit);
        pay_in       = {hit, in_eop, in_err, in_sop, wptr, in_data};
        st_wr_en     = acc;
        st_tag_match = extract;
        st_mem_full  = mem_full;
        st_wptr      = wptr;
        ext_head     = '0;
        if (fifo_empty) begin
            ext_head[BIT_EMPTY] = 1'b1;
        end else begin
            ext_head[DATA_W-1:0]    = pay_head[DATA_W-1:0];
            ext_head[DATA_W +: AW]  = pay_head[DATA_W +: AW];
            ext_head[BIT_SOP]       = pay_head[PW-4];
            ext_head[BIT_ERR]       = pay_head[PW-3];
            ext_head[BIT_EOP]       = pay_head[PW-2];
            ext_head[BIT_HDR]       = pay_head[PW-1];
        end
    end

    // R5
    pkt_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_sop && !in_eop) |=> (state_q == ST_IN));

    // R12
    pkt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_eop) |=> (state_q == ST_OUT));

    // R3
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mem_full || fifo_full)) |-> !mem_we);
endmodule

// File: tb/stream_tag_extractor_bench.sv
module stream_tag_extractor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int FD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_data = '0;
    logic          in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          ofs_we = 1'b0;
    logic [7:0]    ofs_be = '0;
    logic [63:0]   ofs_wdata = '0;
    logic          rdptr_we = 1'b0;
    logic [AW-1:0] rdptr_wdata = '0;
    logic          ext_rd = 1'b0, ext_rd_lo = 1'b0;
    logic [63:0]   ext_head;
    logic          st_mem_full, st_wr_en, st_tag_match;
    logic [AW-1:0] st_wptr;
    logic [9:0]    st_fill;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [AW-1:0] exp_wptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_tag_extractor #(.AW(AW), .FIFO_DEPTH(FD)) u_stream_tag_extractor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ofs_we(ofs_we), .ofs_be(ofs_be), .ofs_wdata(ofs_wdata),
        .rdptr_we(rdptr_we), .rdptr_wdata(rdptr_wdata),
        .ext_rd(ext_rd), .ext_rd_lo(ext_rd_lo), .ext_head(ext_head),
        .st_mem_full(st_mem_full), .st_wr_en(st_wr_en), .st_tag_match(st_tag_match),
        .st_wptr(st_wptr), .st_fill(st_fill)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] entry(input logic [31:0] d, input logic [AW-1:0] wp,
                                          input bit sop, input bit err, input bit eop, input bit hdr);
        logic [63:0] e = '0;
        e[31:0] = d;
        e[32 +: AW] = wp;
        e[58] = sop;
        e[59] = err;
        e[60] = eop;
        e[61] = hdr;
        return e;
    endfunction

    task automatic send_word(input logic [31:0] d, input bit sop, input bit eop, input bit err,
                             input bit exp_ext);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = sop; in_eop = eop; in_err = err;
        #1;
        check({63'b0, in_ready}, 64'd1, "R2 in_ready for word");
        check({63'b0, mem_we}, 64'd1, "R2 mem_we");
        check({60'b0, mem_addr}, {60'b0, exp_wptr}, "R2 mem_addr");
        check({32'b0, mem_wdata}, {32'b0, d}, "R2 mem_wdata");
        check({63'b0, st_wr_en}, 64'd1, "R11 st_wr_en");
        check({63'b0, st_tag_match}, {63'b0, exp_ext}, "R11 st_tag_match");
        @(posedge clk);
        exp_wptr = exp_wptr + 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
    endtask

    task automatic pop_expect(input logic [63:0] exp, input string what);
        @(negedge clk);
        check(ext_head, exp, what);
        ext_rd = 1'b1; ext_rd_lo = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ext_rd = 1'b0; ext_rd_lo = 1'b0;
    endtask

    task automatic set_rptr(input logic [AW-1:0] v);
        @(negedge clk);
        rdptr_we = 1'b1; rdptr_wdata = v;
        @(posedge clk);
        @(negedge clk);
        rdptr_we = 1'b0;
    endtask

    task automatic write_ofs(input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        ofs_we = 1'b1; ofs_be = be; ofs_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ofs_we = 1'b0; ofs_be = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ext_head, 64'h8000_0000_0000_0000, "R1 head empty after reset");
        check({54'b0, st_fill}, 64'd0, "R1 fill zero");
        check({63'b0, in_ready}, 64'd1, "R1 in_ready");
        check({60'b0, st_wptr}, 64'd0, "R1 wptr zero");
        check({63'b0, st_mem_full}, 64'd0, "R1 not full");
    endtask

    task automatic t_default_packet();
        for (int i = 0; i < 9; i++) begin
            send_word(32'hA000_0000 + i, i == 0, i == 8, 1'b0, (i == 0) || (i == 6) || (i == 8));
        end
        check({54'b0, st_fill}, 64'd3, "R5 three entries from default packet");
        pop_expect(entry(32'hA000_0000, 4'd0, 1, 0, 0, 0), "R4 sop entry");
        pop_expect(entry(32'hA000_0006, 4'd6, 0, 0, 0, 1), "R5 offset 6 entry");
        pop_expect(entry(32'hA000_0008, 4'd8, 0, 0, 1, 0), "R8 eop entry layout");
        check({60'b0, st_wptr}, 64'd9, "R11 st_wptr after packet");
    endtask

    task automatic t_dup_offsets();
        write_ofs(8'b0000_1010, 64'hFFFF_FFFF_02FF_02FF);
        set_rptr(exp_wptr);
        for (int i = 0; i < 5; i++) begin
            send_word(32'hB000_0000 + i, i == 0, i == 4, 1'b0, (i == 0) || (i == 2) || (i == 4));
        end
        check({54'b0, st_fill}, 64'd3, "R6 duplicate offsets give one entry");
        pop_expect(entry(32'hB000_0000, 4'd9, 1, 0, 0, 0), "R4 sop entry");
        pop_expect(entry(32'hB000_0002, 4'd11, 0, 0, 0, 1), "R7 lane-written offset 2");
        pop_expect(entry(32'hB000_0004, 4'd13, 0, 0, 1, 0), "R4 eop entry");
        write_ofs(8'hFF, 64'h0606_0606_0606_0606);
    endtask

    task automatic t_after_eop();
        set_rptr(exp_wptr);
        for (int i = 0; i < 3; i++) begin
            send_word(32'hC000_0000 + i, i == 0, i == 2, 1'b0, i != 1);
        end
        for (int i = 3; i < 8; i++) begin
            send_word(32'hC000_0000 + i, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        check({54'b0, st_fill}, 64'd2, "R12 no offset copies outside packet");
        pop_expect(entry(32'hC000_0000, 4'd14, 1, 0, 0, 0), "R4 sop entry");
        pop_expect(entry(32'hC000_0002, 4'd0, 0, 0, 1, 0), "R2 wrapped pointer in entry");
    endtask

    task automatic t_peek_pop();
        logic [63:0] e;
        set_rptr(exp_wptr);
        send_word(32'hD000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        send_word(32'hD000_0001, 1'b0, 1'b0, 1'b1, 1'b1);
        e = entry(32'hD000_0001, 4'd7, 0, 1, 0, 0);
        check({54'b0, st_fill}, 64'd1, "R12 untagged outside word skipped");
        @(negedge clk);
        ext_rd = 1'b1; ext_rd_lo = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ext_rd = 1'b0;
        check({54'b0, st_fill}, 64'd1, "R9 peek keeps entry");
        check(ext_head, e, "R9 head unchanged after peek");
        pop_expect(e, "R4 error entry");
        check({54'b0, st_fill}, 64'd0, "R9 pop removes entry");
        check(ext_head, 64'h8000_0000_0000_0000, "R8 empty head");
    endtask

    task automatic t_mem_full();
        set_rptr(exp_wptr + 4'd3);
        send_word(32'hE000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        send_word(32'hE000_0001, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check({63'b0, st_mem_full}, 64'd1, "R3 mem full raised");
        check({63'b0, in_ready}, 64'd0, "R3 in_ready low when full");
        in_valid = 1'b1; in_data = 32'hE000_0002;
        #1;
        check({63'b0, mem_we}, 64'd0, "R3 no write when full");
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({60'b0, st_wptr}, {60'b0, exp_wptr}, "R3 wptr held when full");
        set_rptr(exp_wptr + 4'd2);
        check({63'b0, st_mem_full}, 64'd0, "R3 full released by rptr");
        check({63'b0, in_ready}, 64'd1, "R3 in_ready back");
    endtask

    task automatic t_fifo_full();
        set_rptr(exp_wptr);
        for (int i = 0; i < FD; i++) begin
            send_word(32'hF000_0000 + i, 1'b0, 1'b0, 1'b1, 1'b1);
        end
        @(negedge clk);
        check({54'b0, st_fill}, 64'd4, "R10 fifo filled");
        check({63'b0, in_ready}, 64'd0, "R10 in_ready low when fifo full");
        check({63'b0, st_mem_full}, 64'd0, "R10 buffer not full");
        pop_expect(entry(32'hF000_0000, 4'd10, 0, 1, 0, 0), "R10 first entry");
        check({63'b0, in_ready}, 64'd1, "R10 in_ready after pop");
        for (int i = 1; i < FD; i++) begin
            pop_expect(entry(32'hF000_0000 + i, 4'd10 + 4'(i), 0, 1, 0, 0), "R10 drain entry");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_packet();
        t_dup_offsets();
        t_after_eop();
        t_peek_pop();
        t_mem_full();
        t_fifo_full();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule